// File: doc/BRIEF.md
# Timer and Watchdog Sharing One Clock Divider

This block pairs an 8-bit timer/counter with a watchdog. The two share a single 8-bit divider. A small control register decides which of the two owns the divider and which power-of-two ratio it applies. For the timer the divider is a prescaler placed in front of the count. For the watchdog it is a postscaler placed after the watchdog's raw period. The unit that does not hold the divider runs undivided. Software cannot read or write the divider. Its count is cleared by the action that belongs to its current owner: a timer write when the timer owns it, a watchdog clear strobe when the watchdog owns it.

The timer counts either the core's instruction-cycle tick or edges on an external clock pin. The pin passes through a synchroniser and then an edge detector, and the edge polarity is selectable. A roll-over from FFh to 00h sets a sticky flag. The flag is gated with an enable bit to form the interrupt. During sleep the timer stops while the watchdog keeps running. The watchdog's base counter advances on a tick from its own oscillator. Each timeout, after post-division, is reported as a one-cycle pulse.

Top module: `tmr_wdt_top`

## Requirements
- R1: After reset the control register reads as all ones. The timer therefore counts falling edges of the external pin with no prescaling, and the watchdog owns the divider. The flag and the interrupt enable are 0. The timer count keeps the value it held before reset.
- R2: Control bit 3 = 0 gives the divider to the timer. With bit 5 = 0 the timer then steps once per 2^(PS+1) instruction ticks, where PS is control bits 2:0, so ratios run from 1:2 up to 1:256.
- R3: Control bit 3 = 1 gives the divider to the watchdog. The timer then steps on every selected tick.
- R4: Control bit 5 = 1 makes the timer count external pin edges through a two-flop synchroniser. Bit 4 = 1 selects falling edges and bit 4 = 0 selects rising edges.
- R5: Writing register 0 loads the timer. The loaded value is held through the next two step requests, after which counting resumes. While the timer owns the divider, the write also clears the divider count.
- R6: A step from FFh to 00h sets the flag, which is bit 0 of register 2. Bit 1 of register 2 is the interrupt enable, and irq_o is the flag AND the enable. The flag stays set until a write to register 2 loads bit 0 from the data.
- R7: While sleep_i is high the timer neither steps nor overflows, and the watchdog keeps counting.
- R8: The watchdog clear strobe always zeroes the watchdog counter. It also zeroes the divider, but only while the watchdog owns the divider.
- R9: When the timer owns the divider, the watchdog times out every 2^WDT_W oscillator ticks. When the watchdog owns it, the period is 2^PS times that. Each timeout shows as a one-cycle pulse on wdt_timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 timer, 1 control, 2 interrupt |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | Instruction-cycle tick, one clock wide |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| sleep_i | input | 1 | Sleep state of the core |
| wdt_osc_tick_i | input | 1 | Watchdog oscillator tick, one clock wide |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| tmr_o | output | 8 | Current timer value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt (flag AND enable) |
| wdt_timeout_o | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The assertions assume that each write strobe lasts one clock and uses a legal register select. They also assume that the watchdog width is at least one bit, so two timeouts can never fall on adjacent cycles. The external pin is taken to hold each level for longer than the synchroniser latency, so that every edge the pin makes is seen exactly once. The stimulus keeps every pin level for four clocks, gives every strobe a single cycle and changes inputs only on the falling clock edge.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {
    SEL_TMR  = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_INT  = 2'd2
  } tw_reg_sel_e;

  localparam int CTRL_W      = 6;
  localparam int BIT_OWNER   = 3;
  localparam int BIT_EDGE    = 4;
  localparam int BIT_SRC     = 5;
  localparam int BIT_FLAG    = 0;
  localparam int BIT_ENABLE  = 1;

endpackage

// File: rtl/tw_ext_sync.sv
module tw_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= cur;
    end
  end

  assign edge_o = fall_sel_i ? (prev_q & ~cur) : (~prev_q & cur);

endmodule

// File: rtl/tw_divider.sv
module tw_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic         own_wdt_i,
  input  logic [2:0]   ps_i,
  output logic         hit_o
);

  localparam int MW = W + 1;

  function automatic logic [W-1:0] ratio_mask(input logic own_wdt, input logic [2:0] ps);
    logic [3:0]    sh;
    logic [MW-1:0] r;
    sh = own_wdt ? {1'b0, ps} : ({1'b0, ps} + 4'd1);
    r  = MW'(1) << sh;
    return W'(r - MW'(1));
  endfunction

  function automatic logic is_hit(input logic [W-1:0] c, input logic [W-1:0] m);
    return (c & m) == m;
  endfunction

  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;

  assign mask  = ratio_mask(own_wdt_i, ps_i);
  assign hit_o = step_i && is_hit(cnt_q, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/tw_timer8.sv
module tw_timer8 #(
  parameter int W          = 8,
  parameter int HOLD_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         inc_req_i,
  output logic [W-1:0] tmr_o,
  output logic         ovf_o
);

  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] hold_q;
  logic [W-1:0]  tmr_q;
  logic          inc_eff;

  assign inc_eff = inc_req_i && (hold_q == '0) && !wr_i;
  assign ovf_o   = inc_eff && (tmr_q == {W{1'b1}});
  assign tmr_o   = tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hold_q <= '0;
    else if (wr_i)                      hold_q <= HW'(HOLD_TICKS);
    else if (inc_req_i && hold_q != '0) hold_q <= hold_q - HW'(1);
  end

  always_ff @(posedge clk) begin
    if (wr_i)         tmr_q <= wr_data_i;
    else if (inc_eff) tmr_q <= tmr_q + W'(1);
  end

endmodule

// File: rtl/tw_wdt.sv
module tw_wdt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  assign wrap_o = tick_i && !clr_i && (cnt_q == {W{1'b1}});
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top #(
  parameter int TMR_W       = 8,
  parameter int DIV_W       = 8,
  parameter int WDT_W       = 6,
  parameter int HOLD_TICKS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             ext_clk_i,
  input  logic             sleep_i,
  input  logic             wdt_osc_tick_i,
  input  logic             wdt_clr_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             ovf_flag_o,
  output logic             irq_o,
  output logic             wdt_timeout_o
);
  import tw_pkg::*;

  logic [CTRL_W-1:0] ctrl_q;
  logic              flag_q, en_q, timeout_q;
  logic              wr_tmr, wr_ctrl, wr_int;
  logic              own_wdt, ext_edge, tmr_evt;
  logic              div_step, div_clr, div_hit;
  logic              tmr_inc_req, tmr_ovf;
  logic              wdt_wrap;
  logic [WDT_W-1:0]  wdt_cnt;

  assign wr_tmr  = wr_en_i && (wr_addr_i == SEL_TMR);
  assign wr_ctrl = wr_en_i && (wr_addr_i == SEL_CTRL);
  assign wr_int  = wr_en_i && (wr_addr_i == SEL_INT);
  assign own_wdt = ctrl_q[BIT_OWNER];

  tw_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i),
    .fall_sel_i(ctrl_q[BIT_EDGE]), .edge_o(ext_edge)
  );

  assign tmr_evt = (ctrl_q[BIT_SRC] ? ext_edge : tick_i) && !sleep_i;

  tw_wdt #(.W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .tick_i(wdt_osc_tick_i),
    .clr_i(wdt_clr_i), .wrap_o(wdt_wrap), .cnt_o(wdt_cnt)
  );

  assign div_step = own_wdt ? wdt_wrap  : tmr_evt;
  assign div_clr  = own_wdt ? wdt_clr_i : wr_tmr;

  tw_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr_i(div_clr), .step_i(div_step),
    .own_wdt_i(own_wdt), .ps_i(ctrl_q[2:0]), .hit_o(div_hit)
  );

  assign tmr_inc_req = own_wdt ? tmr_evt : div_hit;

  tw_timer8 #(.W(TMR_W), .HOLD_TICKS(HOLD_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_tmr), .wr_data_i(wr_data_i),
    .inc_req_i(tmr_inc_req), .tmr_o(tmr_o), .ovf_o(tmr_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '1;
      flag_q    <= 1'b0;
      en_q      <= 1'b0;
      timeout_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (tmr_ovf)     flag_q <= 1'b1;
      else if (wr_int) flag_q <= wr_data_i[BIT_FLAG];
      if (wr_int)  en_q <= wr_data_i[BIT_ENABLE];
      timeout_q <= own_wdt ? div_hit : wdt_wrap;
    end
  end

  assign ovf_flag_o    = flag_q;
  assign irq_o         = flag_q && en_q;
  assign wdt_timeout_o = timeout_q;

endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int TMR_W = 8,
  parameter int WDT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_tmr,
  input logic             wr_int,
  input logic [TMR_W-1:0] wr_data_i,
  input logic [TMR_W-1:0] tmr_o,
  input logic             tmr_ovf,
  input logic             ovf_flag_o,
  input logic             sleep_i,
  input logic             wdt_clr_i,
  input logic [WDT_W-1:0] wdt_cnt,
  input logic             wdt_timeout_o
);

  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_tmr) && tmr_o != $past(tmr_o)) |-> tmr_o == TMR_W'($past(tmr_o) + 1'b1));

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr |=> tmr_o == $past(wr_data_i));

  assert_ovf_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ovf_flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !wr_int) |=> ovf_flag_o);

  assert_sleep_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && !wr_tmr) |=> tmr_o == $past(tmr_o));

  assert_clear_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_i |=> wdt_cnt == '0);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout_o |=> !wdt_timeout_o);

endmodule

bind tmr_wdt_top tw_checker #(.TMR_W(TMR_W), .WDT_W(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_tmr(wr_tmr), .wr_int(wr_int),
  .wr_data_i(wr_data_i), .tmr_o(tmr_o), .tmr_ovf(tmr_ovf),
  .ovf_flag_o(ovf_flag_o), .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i),
  .wdt_cnt(wdt_cnt), .wdt_timeout_o(wdt_timeout_o)
);

// File: tb/tmr_wdt_top_bench.sv
module tmr_wdt_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick = 1'b0, ext_pin = 1'b0, sleep = 1'b0;
  logic       wtick = 1'b0, wclr = 1'b0;
  logic [7:0] tmr;
  logic       flag, irq, wto;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_wdt_top u_tmr_wdt_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .ext_clk_i(ext_pin),
    .sleep_i(sleep), .wdt_osc_tick_i(wtick), .wdt_clr_i(wclr),
    .tmr_o(tmr), .ovf_flag_o(flag), .irq_o(irq), .wdt_timeout_o(wto)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~ext_pin; repeat (4) @(negedge clk);
      ext_pin = ~ext_pin; repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulse_wclr();
    wclr = 1'b1; @(negedge clk); wclr = 1'b0;
  endtask

  task automatic measure_timeout(input int exp, input string req);
    int n = 0;
    wtick = 1'b1;
    while (n < 2000) begin
      @(negedge clk); n++;
      if (wto) break;
    end
    check(n == exp, req, n, exp);
    @(negedge clk);
    check(!wto, "R9 pulse width", int'(wto), 0);
    wtick = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!flag && !irq, "R1 flag/irq reset", int'(flag), 0);
    rst_n = 1'b1; @(negedge clk);
    wr_reg(2'd0, 8'h40);
    check(tmr == 8'h40, "R5 load", tmr, 8'h40);
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check(tmr == 8'h40, "R1 count kept over reset", tmr, 8'h40);
    tick = 1'b1;
    ext_pulses(3);
    tick = 1'b0;
    check(tmr == 8'h43, "R1 default external falling", tmr, 8'h43);
  endtask

  task automatic t_external();
    wr_reg(2'd1, 8'h28);
    wr_reg(2'd0, 8'h10);
    ext_pulses(5);
    check(tmr == 8'h13, "R4 rising edges with R5 hold", tmr, 8'h13);
    wr_reg(2'd1, 8'h38);
    ext_pulses(2);
    check(tmr == 8'h15, "R4 falling edges", tmr, 8'h15);
  endtask

  task automatic t_prescale();
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd0, 8'h00);
    run_ticks(40);
    check(tmr == 8'h08, "R2 ratio 1:4", tmr, 8'h08);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h00);
    run_ticks(20);
    check(tmr == 8'h08, "R2 ratio 1:2", tmr, 8'h08);
    wr_reg(2'd1, 8'h07);
    wr_reg(2'd0, 8'hF0);
    run_ticks(768);
    check(tmr == 8'hF1, "R2 ratio 1:256", tmr, 8'hF1);
  endtask

  task automatic t_write_clears_div();
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd0, 8'h00);
    run_ticks(6);
    wr_reg(2'd0, 8'h20);
    run_ticks(8);
    run_ticks(3);
    check(tmr == 8'h20, "R5 divider cleared by write", tmr, 8'h20);
    run_ticks(1);
    check(tmr == 8'h21, "R5 step after cleared divider", tmr, 8'h21);
  endtask

  task automatic t_wdt_owned_timer();
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd0, 8'h50);
    run_ticks(10);
    check(tmr == 8'h58, "R3 undivided timer", tmr, 8'h58);
  endtask

  task automatic t_overflow();
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd2, 8'h02);
    check(!flag && !irq, "R6 flag cleared", int'(flag), 0);
    wr_reg(2'd0, 8'hFD);
    run_ticks(4);
    check(tmr == 8'hFF && !flag, "R6 no flag before roll-over", tmr, 8'hFF);
    run_ticks(1);
    check(tmr == 8'h00 && flag && irq, "R6 roll-over sets flag", {flag, irq}, 3);
    run_ticks(5);
    wr_reg(2'd0, 8'h33);
    check(flag, "R6 flag sticky", int'(flag), 1);
    wr_reg(2'd2, 8'h02);
    check(!flag && !irq, "R6 software clear", int'(flag), 0);
    wr_reg(2'd2, 8'h01);
    check(flag && !irq, "R6 enable masks irq", int'(irq), 0);
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_sleep();
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd0, 8'hFE);
    run_ticks(2);
    sleep = 1'b1;
    run_ticks(10);
    check(tmr == 8'hFE && !flag, "R7 timer frozen in sleep", tmr, 8'hFE);
    sleep = 1'b0;
    run_ticks(3);
    check(tmr == 8'h01 && flag, "R7 resumes after sleep", tmr, 8'h01);
    wr_reg(2'd2, 8'h00);
  endtask

  task automatic t_watchdog();
    wr_reg(2'd1, 8'h00);
    pulse_wclr();
    sleep = 1'b1;
    measure_timeout(64, "R9 raw period (R7 runs in sleep)");
    sleep = 1'b0;
    wr_reg(2'd1, 8'h0A);
    pulse_wclr();
    measure_timeout(256, "R9 postscale 1:4");
    wr_reg(2'd1, 8'h08);
    pulse_wclr();
    measure_timeout(64, "R9 postscale 1:1");
    wr_reg(2'd1, 8'h0A);
    pulse_wclr();
    wtick = 1'b1; repeat (200) @(negedge clk); wtick = 1'b0;
    pulse_wclr();
    measure_timeout(256, "R8 clear resets divider and counter");
  endtask

  task automatic t_clear_timer_owned();
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd0, 8'h30);
    run_ticks(8);
    run_ticks(2);
    pulse_wclr();
    run_ticks(2);
    check(tmr == 8'h31, "R8 clear leaves timer divider", tmr, 8'h31);
  endtask

  initial begin
    t_reset();
    t_external();
    t_prescale();
    t_write_clears_div();
    t_wdt_owned_timer();
    t_overflow();
    t_sleep();
    t_watchdog();
    t_clear_timer_owned();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule